// File: doc/BRIEF.md
# Dual-Half Prescaled Timer and Event Counter

This block is a 16-bit count engine made of two 8-bit halves. A free-running 2-bit stage divides the cycle clock by four. An 8-bit reloadable divider follows it and produces one timer tick every 4 × (P + 1) cycles, where P is the prescale value. A 2-bit configuration mode decides how the halves are grouped. They can run as two separate timers. They can run as a low timer next to a high event counter. They can also be chained into one 16-bit timer or one 16-bit event counter.

Events arrive on a single input that is already synchronous to the clock. The block counts its rising edges. Each half, or the chained pair, compares its count against a programmable match value. On a match the count returns to zero and a one-cycle interrupt pulse is raised on its own output.

Software configures the block through a small write port. Writing the mode restarts everything, so a new configuration always begins from a known phase.

Top module: `tmr_pair16`

## Requirements
- R1: After reset both outputs are low, the mode is 0, the prescale value is 0 and both match values are all ones. Without any configuration, both halves pulse 1024 cycles after reset release, and every 1024 cycles after that.
- R2: The timer tick fires every 4 × (P + 1) cycles. The first tick comes 4 × (P + 1) cycles after the mode write or the reset release.
- R3: In mode 0 each half counts timer ticks on its own, with period match + 1 ticks. Its interrupt is high for the one cycle after the tick on which its count equalled its match value.
- R4: In mode 1 the low half is a timer as in R3. The high half counts event edges and pulses its interrupt after the edge on which its count equalled its match value.
- R5: In mode 2 the halves form one 16-bit timer. The high half advances only when the low half wraps past all ones. The high interrupt pulses when the full 16 bits equal {match high, match low} on a tick, and the low interrupt stays low.
- R6: In mode 3 the halves form one 16-bit counter of event edges. It has the same 16-bit match behaviour as R5 and a silent low interrupt.
- R7: Only a low-to-high change of the event input counts. An input held high counts once.
- R8: Writing the mode clears both halves, the prescaler and any pending pulse in that cycle. The new mode runs from the next cycle.
- R9: Write address 0 sets the mode (data bits 1:0). Address 1 sets the prescale value, address 2 the low match and address 3 the high match. Writes to addresses 1 to 3 do not restart counting.
- R10: Each interrupt output is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Synchronised external event input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| irq_lo | output | 1 | Low-half match pulse |
| irq_hi | output | 1 | High-half or 16-bit match pulse |

## Verification
The bench predicts the exact cycle of every interrupt and targets these errors:

- **Off-by-one prescale or match periods.** A design with this error pulses one tick early or late, and the pulse lands on the wrong cycle.
- **Carry into the high half.** A chained timer that carries on every tick instead of on a low-half wrap reaches the 16-bit match far too soon.
- **Level counting of events.** Counting a held-high input as many events makes the high half reach its match early.
- **Mode write that does not restart counting.** The old schedule then fires a pulse before the new expected time, and the bench flags that pulse as unexpected.

// File: rtl/tmr_pair16_pkg.sv
package tmr_pair16_pkg;

  typedef enum logic [1:0] {
    MD_SPLIT   = 2'd0,
    MD_TMR_EVT = 2'd1,
    MD_CAS_TMR = 2'd2,
    MD_CAS_EVT = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] CA_MODE  = 2'd0;
  localparam logic [1:0] CA_PRE   = 2'd1;
  localparam logic [1:0] CA_MLO   = 2'd2;
  localparam logic [1:0] CA_MHI   = 2'd3;

  function automatic logic f_chained(input tmr_mode_e m);
    return (m == MD_CAS_TMR) || (m == MD_CAS_EVT);
  endfunction

  function automatic logic f_lo_events(input tmr_mode_e m);
    return m == MD_CAS_EVT;
  endfunction

  function automatic logic f_hi_events(input tmr_mode_e m);
    return (m == MD_TMR_EVT) || (m == MD_CAS_EVT);
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int FIX_W = 2,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] reload,
  output logic             tick
);
  logic [FIX_W-1:0] fix_q;
  logic [PRE_W-1:0] div_q;
  logic             fix_done;
  logic             div_last;

  assign fix_done = &fix_q;
  assign div_last = (div_q >= reload);
  assign tick     = fix_done && div_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fix_q <= '0;
      div_q <= '0;
    end else begin
      fix_q <= fix_q + 1'b1;
      if (fix_done) div_q <= div_last ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic sig_q;
  assign rise = sig && !sig_q;
  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig;
  end
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= restart ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_pair16.sv
module tmr_pair16
  import tmr_pair16_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8,
  parameter int FIX_W  = 2,
  localparam int DATA_W = (HALF_W > PRE_W) ? HALF_W : PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int FULL_W = 2 * HALF_W;

  tmr_mode_e         mode_q;
  logic [PRE_W-1:0]  pre_q;
  logic [HALF_W-1:0] mlo_q, mhi_q;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              mode_wr, pre_tick, evt_rise;
  logic              chained, src_lo, src_hi;
  logic              inc_lo, inc_hi, rst_lo, rst_hi;
  logic              lo_eq, hi_eq, full_eq, lo_top;
  logic              hit_lo, hit_hi;

  assign mode_wr = cfg_we && (cfg_addr == CA_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_SPLIT;
      pre_q  <= '0;
      mlo_q  <= '1;
      mhi_q  <= '1;
    end else if (cfg_we) begin
      case (cfg_addr)
        CA_MODE: mode_q <= tmr_mode_e'(cfg_wdata[1:0]);
        CA_PRE:  pre_q  <= cfg_wdata[PRE_W-1:0];
        CA_MLO:  mlo_q  <= cfg_wdata[HALF_W-1:0];
        default: mhi_q  <= cfg_wdata[HALF_W-1:0];
      endcase
    end
  end

  tmr_prescale #(.FIX_W(FIX_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .reload(pre_q), .tick(pre_tick));

  tmr_edge u_edge (.clk(clk), .rst_n(rst_n), .sig(evt_in), .rise(evt_rise));

  assign chained = f_chained(mode_q);
  assign src_lo  = f_lo_events(mode_q) ? evt_rise : pre_tick;
  assign src_hi  = f_hi_events(mode_q) ? evt_rise : pre_tick;
  assign lo_eq   = (cnt_lo == mlo_q);
  assign hi_eq   = (cnt_hi == mhi_q);
  assign full_eq = ({cnt_hi, cnt_lo} == FULL_W'({mhi_q, mlo_q}));
  assign lo_top  = &cnt_lo;

  always_comb begin
    if (chained) begin
      inc_lo = src_lo;
      rst_lo = full_eq;
      inc_hi = src_lo && (full_eq || lo_top);
      rst_hi = full_eq;
      hit_lo = 1'b0;
      hit_hi = src_lo && full_eq;
    end else begin
      inc_lo = pre_tick;
      rst_lo = lo_eq;
      inc_hi = src_hi;
      rst_hi = hi_eq;
      hit_lo = pre_tick && lo_eq;
      hit_hi = src_hi && hi_eq;
    end
  end

  tmr_half #(.W(HALF_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .inc(inc_lo), .restart(rst_lo), .cnt(cnt_lo));
  tmr_half #(.W(HALF_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(mode_wr), .inc(inc_hi), .restart(rst_hi), .cnt(cnt_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= hit_lo && !mode_wr;
      irq_hi <= hit_hi && !mode_wr;
    end
  end
endmodule

// File: rtl/tmr_pair16_chk.sv
module tmr_pair16_chk #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic [1:0]        mode_q,
  input logic              tick,
  input logic              evt_edge,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              irq_lo,
  input logic              irq_hi
);
  a_r10_lo_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |=> !irq_lo);
  a_r10_hi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |=> !irq_hi);
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (cnt_lo == '0) && (cnt_hi == '0));
  a_r5_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !irq_lo);
  a_r5_hi_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && !mode_wr && cnt_hi == '0 && !(&cnt_lo)) |=> cnt_hi == '0);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3 && !evt_edge && !mode_wr) |=> $stable({cnt_hi, cnt_lo}));
endmodule

bind tmr_pair16 tmr_pair16_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_q(mode_q), .tick(pre_tick),
  .evt_edge(evt_rise), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi));

// File: tb/tmr_pair16_tb_top.sv
module tmr_pair16_tb_top;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       irq_lo, irq_hi;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int w = 0;
  int ev_n = 0;
  bit armed = 0;
  bit done = 0;
  int qlo[$];
  int qhi[$];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_pair16 dut_i (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_lo(irq_lo), .irq_hi(irq_hi));

  // Monitor: pops expected pulse cycles and compares with observed pulses
  always @(negedge clk) if (armed) begin
    if (qlo.size() > 0 && qlo[0] < cyc) begin
      checks++; errors++;
      $display("FAIL irq_lo missed pulse: actual none expected cycle %0d", qlo.pop_front());
    end
    if (irq_lo) begin
      checks++;
      if (qlo.size() > 0 && qlo[0] == cyc) void'(qlo.pop_front());
      else begin errors++; $display("FAIL irq_lo unexpected: actual cycle %0d expected %0d", cyc, (qlo.size() > 0) ? qlo[0] : -1); end
    end
    if (qhi.size() > 0 && qhi[0] < cyc) begin
      checks++; errors++;
      $display("FAIL irq_hi missed pulse: actual none expected cycle %0d", qhi.pop_front());
    end
    if (irq_hi) begin
      checks++;
      if (qhi.size() > 0 && qhi[0] == cyc) void'(qhi.pop_front());
      else begin errors++; $display("FAIL irq_hi unexpected: actual cycle %0d expected %0d", cyc, (qhi.size() > 0) ? qhi[0] : -1); end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0d expected %0d", what, act, exp); end
  endtask

  // R9: address 0 mode, 1 prescale, 2 low match, 3 high match
  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_mode(input logic [1:0] m);
    armed = 0;
    cfg_write(2'd0, {6'd0, m});
    qlo.delete(); qhi.delete();
    w = cyc; ev_n = 0;
    armed = 1;
  endtask

  task automatic push_series(input bit hi, input int first, input int period, input int last);
    for (int t = first; t <= last; t += period) begin
      if (hi) qhi.push_back(t); else qlo.push_back(t);
    end
  endtask

  task automatic end_phase(input int last, input string tag);
    while (cyc < last) @(negedge clk);
    #1;
    armed = 0;
    check(qlo.size() == 0 && qhi.size() == 0, {tag, " all expected pulses seen"},
          qlo.size() + qhi.size(), 0);
  endtask

  task automatic ev_pulse(input int hlen, input int llen, input int every);
    evt_in = 1'b1;
    @(negedge clk);
    ev_n++;
    if (ev_n % every == 0) qhi.push_back(cyc);
    for (int i = 1; i < hlen; i++) @(negedge clk);
    evt_in = 1'b0;
    for (int i = 0; i < llen; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_lo == 1'b0 && irq_hi == 1'b0, "R1 outputs low in reset", {irq_lo, irq_hi}, 0);
    rst_n = 1'b1;
    // R1: defaults give prescale 0, matches 255, mode 0 -> period 4*256
    qlo.delete(); qhi.delete();
    w = cyc; armed = 1;
    check(irq_lo == 1'b0 && irq_hi == 1'b0, "R1 outputs low after reset", {irq_lo, irq_hi}, 0);
    push_series(0, w + 1024, 1024, w + 2100);
    push_series(1, w + 1024, 1024, w + 2100);
    end_phase(w + 2100, "R1 defaults");

    // R3/R2: split timers, prescale 0
    cfg_write(2'd1, 8'd0); cfg_write(2'd2, 8'd2); cfg_write(2'd3, 8'd4);
    start_mode(2'd0);
    push_series(0, w + 12, 12, w + 100);
    push_series(1, w + 20, 20, w + 100);
    end_phase(w + 100, "R3 split P0");

    // R2/R3: prescale 2 -> tick every 12 cycles
    cfg_write(2'd1, 8'd2); cfg_write(2'd2, 8'd1); cfg_write(2'd3, 8'd0);
    start_mode(2'd0);
    push_series(0, w + 24, 24, w + 100);
    push_series(1, w + 12, 12, w + 100);
    end_phase(w + 100, "R2 prescale 2");

    // R8: a mode rewrite restarts the schedule
    cfg_write(2'd1, 8'd0); cfg_write(2'd2, 8'd5); cfg_write(2'd3, 8'd5);
    start_mode(2'd0);
    end_phase(w + 10, "R8 first run");
    start_mode(2'd0);
    push_series(0, w + 24, 24, w + 60);
    push_series(1, w + 24, 24, w + 60);
    end_phase(w + 60, "R8 restart");

    // R5: chained 16-bit timer, match 0x0103 = 259 -> 260 ticks of 4 cycles
    cfg_write(2'd2, 8'd3); cfg_write(2'd3, 8'd1);
    start_mode(2'd2);
    push_series(1, w + 1040, 1040, w + 2200);
    end_phase(w + 2200, "R5 chained timer");

    // R4/R7: low timer period 16, high counts edges, every 3rd edge
    cfg_write(2'd2, 8'd3); cfg_write(2'd3, 8'd2);
    start_mode(2'd1);
    push_series(0, w + 16, 16, w + 160);
    for (int k = 0; k < 20; k++) ev_pulse(2, 3, 3);
    ev_pulse(12, 3, 3);  // R7: held high counts once
    ev_pulse(2, 3, 3);
    ev_pulse(2, 3, 3);
    end_phase(w + 160, "R4 timer plus events");

    // R6: chained event counter, match 0x0100 -> pulse on edge 257
    cfg_write(2'd2, 8'd0); cfg_write(2'd3, 8'd1);
    start_mode(2'd3);
    for (int k = 0; k < 300; k++) ev_pulse(1, 1, 257);
    end_phase(cyc + 2, "R6 chained events");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule